// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block keeps the replacement state for every set of a 4-way set-associative cache and names the way to evict when a line must be filled. It does not track a full recency order. Each set holds a three-node binary tree: one root bit chooses between the lower pair of ways (0/1) and the upper pair (2/3), and one bit under each side chooses within that pair. Each node bit records which side was used last, so walking the tree against those bits leads away from recent use and gives a cheap approximation of least-recently-used.

The cache controller reports every hit or fill as an access: it names the set and the way, and the block rewrites the nodes on that way's path at the next clock edge. Separately, the controller presents a set index on the victim port and reads back the way to replace. The victim output is combinational from the stored state, so a query made in the same cycle as an access to the same set returns the choice from before that access. The block stores 128 sets of 3 bits. It does not hold tags or data and does not decide hit or miss.

Top module: `tree_plru`

## Requirements
- R1: After reset every set's tree bits are all 0, so the victim reported for any set is way 3.
- R2: An access with `acc_valid` high writes the root of set `acc_set` with bit 1 of `acc_way` (0 = lower pair, ways 0/1; 1 = upper pair, ways 2/3), and writes the child on that side with bit 0 of `acc_way` (0 = lower way of the pair, 1 = upper way).
- R3: The child node on the side not taken by the accessed way keeps its previous value.
- R4: An access changes no set other than `acc_set`.
- R5: With `acc_valid` low, no set changes, whatever `acc_set` and `acc_way` hold.
- R6: The victim walk reads each node with the opposite meaning: 0 steps to the upper side and 1 steps to the lower side. The root selects the pair and the chosen child selects the way, with ways numbered 0 to 3.
- R7: `vic_way` depends only on the stored state of set `vic_set`. An access in the same cycle becomes visible only after the clock edge.
- R8: Straight after an access to a set, the victim for that set is never the way just accessed.
- R9: Asserting `rst_n` at any time clears every set again. Release is synchronised to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid | input | 1 | An access (hit or fill) happens this cycle |
| acc_set | input | 7 | Set index of the access |
| acc_way | input | 2 | Way that was hit or filled |
| vic_set | input | 7 | Set whose victim is requested |
| vic_way | output | 2 | Way to replace in `vic_set` |

## Verification
The tree rules are tried with single accesses to fresh sets, which show each way's path and the opposite reading of the bits. They are also tried with two-access sequences into opposite halves, which separate a correct design from one that clears the untouched child. A full sweep over ways 0 to 3 checks that the first-used way comes back as the victim. Same-cycle access and query to one set shows whether the output reads old or new state, and accesses to the first and last set next to their neighbours expose index decoding faults. A long pseudo-random run over all sets and ways is compared with a behavioural model of the tree, and a mid-run reset checks that all state is cleared.

// File: rtl/plru_pkg.sv
package plru_pkg;

  localparam int unsigned DEF_SETS = 128;
  localparam int unsigned DEF_WAYS = 4;

  // Meaning of a stored node bit when it is written on an access.
  typedef enum logic {
    SIDE_LOW  = 1'b0,
    SIDE_HIGH = 1'b1
  } side_e;

  // The walk toward a victim goes to the side opposite the recorded one.
  function automatic side_e away_from(input logic node_bit);
    return (node_bit == 1'b0) ? SIDE_HIGH : SIDE_LOW;
  endfunction

endpackage

// File: rtl/plru_rst_sync.sv
module plru_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/plru_update.sv
module plru_update #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned LEVELS = $clog2(WAYS),
  localparam int unsigned NODES  = WAYS - 1,
  localparam int unsigned NODE_W = $clog2(NODES)
) (
  input  logic [NODES-1:0]  cur_bits,
  input  logic [LEVELS-1:0] way,
  output logic [NODES-1:0]  nxt_bits
);

  logic [NODE_W-1:0] node;

  // Follow the accessed way from the root; each visited node records
  // the side that was taken. Nodes off the path keep their value.
  always_comb begin
    nxt_bits = cur_bits;
    node     = '0;
    for (int lvl = 0; lvl < int'(LEVELS); lvl++) begin
      nxt_bits[node] = way[LEVELS-1-lvl];
      node = NODE_W'(2 * int'(node) + 1 + int'(way[LEVELS-1-lvl]));
    end
  end

  // R3: an access rewrites at most one node per tree level
  always_comb begin
    p_path_only_r3: assert ($countones(nxt_bits ^ cur_bits) <= LEVELS || $isunknown(cur_bits))
      else $error("more tree nodes changed than lie on one path");
  end

endmodule

// File: rtl/plru_victim.sv
module plru_victim #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned LEVELS = $clog2(WAYS),
  localparam int unsigned NODES  = WAYS - 1,
  localparam int unsigned NODE_W = $clog2(NODES)
) (
  input  logic [NODES-1:0]  tree_bits,
  output logic [LEVELS-1:0] victim
);

  import plru_pkg::*;

  logic [NODE_W-1:0] node;
  side_e             step;

  // Walk from the root, at every node stepping away from the recorded side.
  always_comb begin
    victim = '0;
    node   = '0;
    step   = SIDE_LOW;
    for (int lvl = 0; lvl < int'(LEVELS); lvl++) begin
      step = away_from(tree_bits[node]);
      victim[LEVELS-1-lvl] = logic'(step);
      node = NODE_W'(2 * int'(node) + 1 + int'(logic'(step)));
    end
  end

endmodule

// File: rtl/plru_state_array.sv
module plru_state_array #(
  parameter int unsigned NUM_SETS = 128,
  parameter int unsigned WAYS     = 4,
  localparam int unsigned SET_W  = $clog2(NUM_SETS),
  localparam int unsigned LEVELS = $clog2(WAYS),
  localparam int unsigned NODES  = WAYS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [LEVELS-1:0] acc_way,
  input  logic [SET_W-1:0]  rd_set,
  output logic [NODES-1:0]  rd_bits
);

  logic [NUM_SETS-1:0][NODES-1:0] state_q;
  logic [NUM_SETS-1:0][NODES-1:0] state_d;
  logic [NODES-1:0]               acc_cur;
  logic [NODES-1:0]               acc_nxt;
  logic                           wr_en;

  assign acc_cur = state_q[acc_set];

  plru_update #(.WAYS(WAYS)) u_update (
    .cur_bits (acc_cur),
    .way      (acc_way),
    .nxt_bits (acc_nxt)
  );

  assign wr_en = acc_valid;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      state_d[acc_set] = acc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (wr_en) begin
      state_q <= state_d;
    end
  end

  assign rd_bits = state_q[rd_set];

  // R2: root of the accessed set records the half holding the accessed way
  p_root_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> state_q[$past(acc_set)][0] == $past(acc_way[LEVELS-1]))
    else $error("root bit does not record accessed half");

  // R4, R5: a set that is not the target of a valid access holds its bits
  for (genvar s = 0; s < int'(NUM_SETS); s++) begin : g_hold
    p_set_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_set == SET_W'(s)) |=> $stable(state_q[s]))
      else $error("set %0d changed without an access", s);
  end

endmodule

// File: rtl/tree_plru.sv
module tree_plru #(
  parameter int unsigned NUM_SETS = plru_pkg::DEF_SETS,
  parameter int unsigned WAYS     = plru_pkg::DEF_WAYS,
  localparam int unsigned SET_W  = $clog2(NUM_SETS),
  localparam int unsigned LEVELS = $clog2(WAYS),
  localparam int unsigned NODES  = WAYS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [LEVELS-1:0] acc_way,
  input  logic [SET_W-1:0]  vic_set,
  output logic [LEVELS-1:0] vic_way
);

  logic             rst_s_n;
  logic [NODES-1:0] vic_bits;

  plru_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  plru_state_array #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_state (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .acc_valid (acc_valid),
    .acc_set   (acc_set),
    .acc_way   (acc_way),
    .rd_set    (vic_set),
    .rd_bits   (vic_bits)
  );

  plru_victim #(.WAYS(WAYS)) u_victim (
    .tree_bits (vic_bits),
    .victim    (vic_way)
  );

  // R1: leaving reset, every set points at the highest way
  p_reset_victim_r1: assert property (@(posedge clk)
    $rose(rst_s_n) |-> vic_way == '1)
    else $error("victim after reset is not the top way");

  // R8: the way just accessed is never the next victim of its set
  p_not_recent_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_valid && rst_s_n) |=> (vic_set != $past(acc_set)) || (vic_way != $past(acc_way)))
    else $error("victim equals most recent way");

endmodule

// File: tb/tree_plru_tb.sv
`timescale 1ns/1ps
module tree_plru_tb;

  logic       clk;
  logic       rst_n;
  logic       acc_valid;
  logic [6:0] acc_set;
  logic [1:0] acc_way;
  logic [6:0] vic_set;
  logic [1:0] vic_way;

  int n_checks;
  int n_fails;
  logic [2:0] mdl [128];

  tree_plru u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_set   (acc_set),
    .acc_way   (acc_way),
    .vic_set   (vic_set),
    .vic_way   (vic_way)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Model: bit0 root (1 = upper pair), bit1 lower-pair child, bit2 upper-pair child.
  function automatic logic [1:0] model_victim(input logic [2:0] b);
    if (b[0] == 1'b0) return b[2] ? 2'd2 : 2'd3;
    else              return b[1] ? 2'd0 : 2'd1;
  endfunction

  function automatic logic [2:0] model_access(input logic [2:0] b, input logic [1:0] w);
    logic [2:0] r;
    r = b;
    r[0] = w[1];
    if (w[1]) r[2] = w[0];
    else      r[1] = w[0];
    return r;
  endfunction

  task automatic check_way(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: vic_way=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic query(input string req, input int s);
    vic_set = 7'(s);
    #0.5;
    check_way(req, vic_way, model_victim(mdl[s]));
  endtask

  task automatic do_access(input int s, input int w);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_set   = 7'(s);
    acc_way   = 2'(w);
    @(negedge clk);
    acc_valid = 1'b0;
    mdl[s] = model_access(mdl[s], 2'(w));
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 128; s++) mdl[s] = 3'b000;
  endtask

  task automatic t_reset_state();
    for (int s = 0; s < 128; s += 9) begin
      vic_set = 7'(s);
      #0.5;
      check_way("R1", vic_way, 2'd3);
    end
  endtask

  task automatic t_single_paths();
    // way 1: root->lower, lower child->upper; victim from upper pair = way 3 (R2, R6)
    do_access(5, 1);
    vic_set = 7'd5; #0.5; check_way("R2", vic_way, 2'd3);
    do_access(6, 3);
    vic_set = 7'd6; #0.5; check_way("R6", vic_way, 2'd1);
    do_access(7, 2);
    vic_set = 7'd7; #0.5; check_way("R6", vic_way, 2'd1);
    do_access(8, 0);
    vic_set = 7'd8; #0.5; check_way("R2", vic_way, 2'd3);
  endtask

  task automatic t_sibling_kept();
    // way 0 then way 2: lower child still 0, so victim is way 1 (R3)
    do_access(20, 0);
    do_access(20, 2);
    vic_set = 7'd20; #0.5; check_way("R3", vic_way, 2'd1);
    // way 1 then way 3: lower child still 1, victim way 0
    do_access(21, 1);
    do_access(21, 3);
    vic_set = 7'd21; #0.5; check_way("R3", vic_way, 2'd0);
  endtask

  task automatic t_sweep();
    for (int w = 0; w < 4; w++) do_access(40, w);
    vic_set = 7'd40; #0.5; check_way("R6", vic_way, 2'd0);
    for (int w = 3; w >= 0; w--) do_access(41, w);
    vic_set = 7'd41; #0.5; check_way("R6", vic_way, 2'd3);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    acc_valid = 1'b1; acc_set = 7'd30; acc_way = 2'd3; vic_set = 7'd30;
    #0.5;
    check_way("R7", vic_way, 2'd3);
    @(negedge clk);
    acc_valid = 1'b0;
    mdl[30] = model_access(mdl[30], 2'd3);
    #0.5;
    check_way("R7", vic_way, 2'd1);
  endtask

  task automatic t_edges();
    do_access(0, 3);
    do_access(127, 0);
    query("R4", 0);
    query("R4", 1);
    query("R4", 126);
    query("R4", 127);
    vic_set = 7'd1; #0.5; check_way("R4", vic_way, 2'd3);
  endtask

  task automatic t_valid_low();
    @(negedge clk);
    acc_valid = 1'b0; acc_set = 7'd50; acc_way = 2'd3;
    repeat (3) @(negedge clk);
    vic_set = 7'd50; #0.5; check_way("R5", vic_way, 2'd3);
    acc_set = 7'd5; acc_way = 2'd2;
    repeat (2) @(negedge clk);
    query("R5", 5);
  endtask

  task automatic t_random();
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_access(int'(lfsr[6:0]), int'(lfsr[9:8]));
      vic_set = lfsr[6:0]; #0.5;
      if (vic_way == lfsr[9:8]) check_way("R8", vic_way, ~lfsr[9:8]);
      query("R2", int'(lfsr[6:0]));
      query("R4", int'(lfsr[14:8]));
    end
  endtask

  task automatic t_mid_reset();
    do_access(60, 0);
    do_access(61, 2);
    apply_reset();
    for (int s = 0; s < 128; s++) begin
      vic_set = 7'(s); #0.5;
      check_way("R9", vic_way, 2'd3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    acc_valid = 1'b0;
    acc_set = '0;
    acc_way = '0;
    vic_set = '0;
    rst_n = 1'b0;
    apply_reset();
    t_reset_state();
    t_single_paths();
    t_sibling_kept();
    t_sweep();
    t_same_cycle();
    t_edges();
    t_valid_low();
    t_random();
    t_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule